// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This block is a purely combinational datapath for scaled-index address arithmetic. It takes an index operand, scales it by 2, 4, 8 or 16 through a left shift, and adds the scaled value to a base operand. The sum wraps modulo 2^XLEN. No carry or overflow is reported.

Before the shift, the index can be used at full width, or its low half can be taken and widened. The widening is either by sign extension or by zero extension, so 32-bit indices can be mixed with 64-bit base values. When the record flag is set, the unit also produces a four-bit condition field. This field classifies the sum as negative, positive or zero and passes through an externally supplied summary-overflow bit.

Top module: `saa_unit`

## Requirements
- R1: The left shift applied to the extended index equals `scale_i` plus one, so `scale_i` values 0, 1, 2 and 3 give shifts of 1, 2, 3 and 4 positions, with zeros filled in at the low end.
- R2: `sum_o` equals the shifted index plus `opa_i`, truncated to XLEN bits (wrap-around). Because the shift is at least one, bit 0 of `sum_o` always equals bit 0 of `opa_i`.
- R3: With `mode_i` = 2'b00 the whole `opb_i` is shifted, and bits moved past bit XLEN-1 are lost.
- R4: With `mode_i` = 2'b01 only the low XLEN/2 bits of `opb_i` are used. The upper half is filled with copies of bit XLEN/2-1 before the shift.
- R5: With `mode_i` = 2'b10 the low XLEN/2 bits of `opb_i` are zero-extended before the shift. The code 2'b11 behaves like 2'b00.
- R6: When `rec_i` is 1, `cr_o[3]` flags a negative sum (top bit set), `cr_o[2]` flags a nonzero non-negative sum, and `cr_o[1]` flags a zero sum. Exactly one of these three is set.
- R7: When `rec_i` is 1, `cr_o[0]` equals `so_i`.
- R8: When `rec_i` is 0, `cr_o` is 4'b0000 whatever the sum and `so_i` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | XLEN | Base operand added to the scaled index |
| opb_i | input | XLEN | Index operand, extended per mode and shifted |
| scale_i | input | 2 | Shift selector; shift = value + 1 |
| mode_i | input | 2 | Index width: 00 full, 01 signed low half, 10 unsigned low half, 11 full |
| rec_i | input | 1 | Record flag enabling the condition field |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| sum_o | output | XLEN | Wrapped sum |
| cr_o | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The unit holds no state, so both `sum_o` and `cr_o` are due in the same cycle that the inputs change, after zero clock edges. The bench drives a new input set shortly after each rising edge. It samples both outputs at the following falling edge, once all combinational paths have settled and before the next stimulus. Each sample is compared with values that bench functions compute from the requirements.

// File: rtl/saa_pkg.sv
package saa_pkg;

  typedef enum logic [1:0] {
    SAA_FULL  = 2'b00,
    SAA_SWORD = 2'b01,
    SAA_UWORD = 2'b10,
    SAA_ALT   = 2'b11
  } saa_mode_e;

  localparam int unsigned SAA_CR_W   = 4;
  localparam int unsigned SAA_CR_NEG = 3;
  localparam int unsigned SAA_CR_POS = 2;
  localparam int unsigned SAA_CR_ZER = 1;
  localparam int unsigned SAA_CR_SO  = 0;

endpackage

// File: rtl/saa_operand_prep.sv
module saa_operand_prep
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] idx_i,
  input  saa_mode_e       mode_i,
  output logic [XLEN-1:0] ext_o
);

  localparam int unsigned HALF = XLEN / 2;

  logic [HALF-1:0] low_half;
  logic            low_sign;

  assign low_half = idx_i[HALF-1:0];
  assign low_sign = idx_i[HALF-1];

  always_comb begin
    unique case (mode_i)
      SAA_SWORD: ext_o = {{(XLEN-HALF){low_sign}}, low_half};
      SAA_UWORD: ext_o = {{(XLEN-HALF){1'b0}}, low_half};
      default:   ext_o = idx_i;
    endcase
  end

endmodule

// File: rtl/saa_scaler.sv
module saa_scaler #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 2
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  sel_i,
  output logic [XLEN-1:0] shifted_o
);

  localparam int unsigned NSH = 1 << SHW;

  logic [XLEN-1:0] cand [NSH];

  for (genvar k = 0; k < NSH; k++) begin : g_cand
    assign cand[k] = {val_i[XLEN-2-k:0], {(k+1){1'b0}}};
  end

  assign shifted_o = cand[sel_i];

endmodule

// File: rtl/saa_cond.sv
module saa_cond
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]     sum_i,
  input  logic                rec_i,
  input  logic                so_i,
  output logic [SAA_CR_W-1:0] cr_o
);

  logic neg, zer;

  assign neg = sum_i[XLEN-1];
  assign zer = (sum_i == '0);

  always_comb begin
    cr_o = '0;
    if (rec_i) begin
      cr_o[SAA_CR_NEG] = neg;
      cr_o[SAA_CR_POS] = !neg && !zer;
      cr_o[SAA_CR_ZER] = zer;
      cr_o[SAA_CR_SO]  = so_i;
    end
  end

endmodule

// File: rtl/saa_unit.sv
module saa_unit
  import saa_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 2
) (
  input  logic [XLEN-1:0]     opa_i,
  input  logic [XLEN-1:0]     opb_i,
  input  logic [SHW-1:0]      scale_i,
  input  logic [1:0]          mode_i,
  input  logic                rec_i,
  input  logic                so_i,
  output logic [XLEN-1:0]     sum_o,
  output logic [SAA_CR_W-1:0] cr_o
);

  saa_mode_e       mode;
  logic [XLEN-1:0] idx_ext;
  logic [XLEN-1:0] idx_scaled;

  assign mode = saa_mode_e'(mode_i);

  saa_operand_prep #(.XLEN(XLEN)) u_prep (
    .idx_i  (opb_i),
    .mode_i (mode),
    .ext_o  (idx_ext)
  );

  saa_scaler #(.XLEN(XLEN), .SHW(SHW)) u_scale (
    .val_i     (idx_ext),
    .sel_i     (scale_i),
    .shifted_o (idx_scaled)
  );

  assign sum_o = idx_scaled + opa_i;

  saa_cond #(.XLEN(XLEN)) u_cond (
    .sum_i (sum_o),
    .rec_i (rec_i),
    .so_i  (so_i),
    .cr_o  (cr_o)
  );

endmodule

// File: rtl/saa_unit_chk.sv
module saa_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 2
) (
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [SHW-1:0]  scale_i,
  input logic [1:0]      mode_i,
  input logic            rec_i,
  input logic            so_i,
  input logic [XLEN-1:0] sum_o,
  input logic [3:0]      cr_o
);

  logic unused_chk;
  assign unused_chk = ^{opb_i, scale_i, mode_i};

  always_comb begin
    p_low_bit_r2: assert (sum_o[0] == opa_i[0])
      else $error("p_low_bit_r2");
    if (rec_i) begin
      p_one_class_r6: assert ($onehot(cr_o[3:1]))
        else $error("p_one_class_r6");
      p_zero_flag_r6: assert ((sum_o == '0) == cr_o[1])
        else $error("p_zero_flag_r6");
      p_so_copy_r7: assert (cr_o[0] == so_i)
        else $error("p_so_copy_r7");
    end else begin
      p_cr_quiet_r8: assert (cr_o == 4'b0000)
        else $error("p_cr_quiet_r8");
    end
  end

endmodule

bind saa_unit saa_unit_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .scale_i (scale_i),
  .mode_i  (mode_i),
  .rec_i   (rec_i),
  .so_i    (so_i),
  .sum_o   (sum_o),
  .cr_o    (cr_o)
);

// File: tb/tb_saa_unit.sv
module tb_saa_unit;

  localparam int unsigned XLEN = 64;
  localparam int unsigned HALF = XLEN / 2;

  logic clk;
  logic rst_n;

  logic [XLEN-1:0] opa_i, opb_i, sum_o;
  logic [1:0]      scale_i, mode_i;
  logic            rec_i, so_i;
  logic [3:0]      cr_o;

  int checks;
  int errors;
  bit done;

  saa_unit #(.XLEN(XLEN), .SHW(2)) dut (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .scale_i (scale_i),
    .mode_i  (mode_i),
    .rec_i   (rec_i),
    .so_i    (so_i),
    .sum_o   (sum_o),
    .cr_o    (cr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [XLEN-1:0] exp_sum(
    input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
    input logic [1:0] sc, input logic [1:0] md);
    logic [XLEN-1:0] e;
    case (md)
      2'b01:   e = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
      2'b10:   e = {{HALF{1'b0}}, b[HALF-1:0]};
      default: e = b;
    endcase
    return (e << (int'(sc) + 1)) + a;
  endfunction

  function automatic logic [3:0] exp_cr(
    input logic [XLEN-1:0] s, input logic rec, input logic so);
    if (!rec) return 4'b0000;
    return {s[XLEN-1], !s[XLEN-1] && (s != '0), s == '0, so};
  endfunction

  task automatic apply_and_check(
    input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
    input logic [1:0] sc, input logic [1:0] md,
    input logic rec, input logic so, input string tag);
    logic [XLEN-1:0] es;
    logic [3:0]      ec;
    @(posedge clk);
    #1;
    opa_i = a; opb_i = b; scale_i = sc; mode_i = md; rec_i = rec; so_i = so;
    es = exp_sum(a, b, sc, md);
    ec = exp_cr(es, rec, so);
    @(negedge clk);
    checks++;
    if (sum_o !== es) begin
      errors++;
      $display("FAIL %s sum actual=%h expected=%h", tag, sum_o, es);
    end
    checks++;
    if (cr_o !== ec) begin
      errors++;
      $display("FAIL %s cr actual=%b expected=%b", tag, cr_o, ec);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    opa_i = '0; opb_i = '0; scale_i = '0; mode_i = '0; rec_i = 1'b0; so_i = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R8: idle inputs, record off
    apply_and_check('0, '0, 2'd0, 2'b00, 1'b0, 1'b1, "R8 idle");
    // R1: each shift amount
    for (int s = 0; s < 4; s++)
      apply_and_check(64'd5, 64'd1, 2'(s), 2'b00, 1'b1, 1'b0, "R1 shift");
    // R3: top bits dropped
    apply_and_check(64'd0, 64'hF000_0000_0000_0001, 2'd3, 2'b00, 1'b1, 1'b0, "R3 drop");
    // R4: sign extension from bit 31
    apply_and_check(64'd0, 64'h1234_5678_8000_0001, 2'd0, 2'b01, 1'b1, 1'b0, "R4 neg");
    apply_and_check(64'd100, 64'hFFFF_FFFF_7FFF_FFFF, 2'd1, 2'b01, 1'b1, 1'b1, "R4 pos");
    // R5: zero extension and alt code
    apply_and_check(64'd0, 64'hFFFF_FFFF_8000_0001, 2'd2, 2'b10, 1'b1, 1'b0, "R5 uword");
    apply_and_check(64'd3, 64'hF000_0000_0000_0001, 2'd0, 2'b11, 1'b1, 1'b0, "R5 alt");
    // R2: wrap to zero, R6 zero flag
    apply_and_check(64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 2'd0, 2'b00, 1'b1, 1'b0, "R2 wrap");
    // R6 negative, R7 so passed
    apply_and_check(64'h8000_0000_0000_0000, 64'd0, 2'd3, 2'b00, 1'b1, 1'b1, "R6 R7 neg");
    // R8: nonzero result with so set, record off
    apply_and_check(64'h8000_0000_0000_0000, 64'd7, 2'd1, 2'b01, 1'b0, 1'b1, "R8 quiet");

    void'($urandom(32'd1789));
    for (int i = 0; i < 3000; i++) begin
      logic [XLEN-1:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 17 == 0) ra = '0;
      apply_and_check(ra, rb, 2'($urandom()), 2'($urandom()),
                      1'($urandom()), 1'($urandom()), "R2 R6 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic unused_tb;
  assign unused_tb = rst_n;

endmodule